// File: doc/BRIEF.md
# Accumulator Stored-Program Core

This block is a very small processor built around one 8-bit accumulator and an 8-bit program counter. It reads an 8-bit-wide program store through a read-only port. The core places an address on that port, and the store returns the word at that address within the same cycle. The core runs a short state machine for each instruction. It fetches the word and classifies it. For an add, it fetches the following word as a raw operand. It then updates the accumulator.

The instruction set has three operations: halt, clear-accumulator, and add-immediate. Add-immediate takes its operand from the next word. Any other word value is skipped as a no-op. The accumulator is always visible on an output, and a halted flag reports when the program has ended. A run input pauses the core in place. A synchronous reset restarts the program from address zero.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous active-high reset sets the program address to 0, the accumulator to 0 and the halted flag to 0, including when reset arrives in the middle of a program. The first word fetched after reset is the word at address 0.
- R2: An instruction word of value 1 sets the accumulator to 0.
- R3: An instruction word of value 2 adds the word at the next address to the accumulator. That operand word is used only as data, even if its value is 0, 1 or 2.
- R4: The addition wraps modulo 256, and no carry is kept.
- R5: An instruction word of value 0 halts the core. `halted_o` then stays 1 until reset, and the accumulator and program address no longer change, whatever the memory holds.
- R6: The program address advances by exactly one for each word consumed, whether instruction or operand. After a halt it rests at the halt word's address plus one.
- R7: Any instruction word other than 0, 1 or 2 changes nothing except that the program address moves past it.
- R8: Counted in clock cycles from reset release, a halt takes 2 cycles, a no-op 2, a clear 3 and an add-immediate 4. The program 1, 2, 7, 2, 5, 0 therefore halts after 13 cycles with 12 in the accumulator.
- R9: While `run_i` is 0, the state, the program address and the accumulator hold their values. Execution resumes unchanged when `run_i` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Step enable; 0 pauses the core |
| imem_addr_o | output | 8 | Program store read address (program counter) |
| imem_data_i | input | 8 | Word read from the program store, same cycle |
| acc_o | output | 8 | Accumulator value |
| halted_o | output | 1 | 1 once a halt word has executed, until reset |

## Verification
The hardest situation to reach is an operand word that looks like an opcode. Only the decode path separates it from an instruction, so programs place the values 0 and 2 directly after add words. The result then shows whether they were consumed as data. A second hard case is the state after halt. To show that the core no longer reads or acts on the store, the bench rewrites the whole program memory with add words once the core has halted. It also pauses the core partway through an add sequence, then checks both the frozen outputs and the cycle total once the core is resumed.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    // Instruction word values
    localparam int OPC_HALT = 0;
    localparam int OPC_CLR  = 1;
    localparam int OPC_ADDI = 2;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_FETCH   = 3'd0,
        ST_DECODE  = 3'd1,
        ST_OPFETCH = 3'd2,
        ST_EXEC    = 3'd3,
        ST_HALT    = 3'd4
    } cpu_state_e;

    // Decoded instruction class
    typedef enum logic [1:0] {
        OP_HALT = 2'd0,
        OP_CLR  = 2'd1,
        OP_ADDI = 2'd2,
        OP_NOP  = 2'd3
    } op_class_e;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] instr_i,
    output op_class_e         op_o
);

    always_comb begin
        if (instr_i == DATA_W'(OPC_HALT)) begin
            op_o = OP_HALT;
        end else if (instr_i == DATA_W'(OPC_CLR)) begin
            op_o = OP_CLR;
        end else if (instr_i == DATA_W'(OPC_ADDI)) begin
            op_o = OP_ADDI;
        end else begin
            op_o = OP_NOP;
        end
    end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_class_e         op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] acc_o
);

    // Sum truncated to DATA_W: wraps, no carry retained
    logic [DATA_W-1:0] sum;

    always_comb begin
        sum = acc_i + opnd_i;
        unique case (op_i)
            OP_CLR:  acc_o = '0;
            OP_ADDI: acc_o = sum;
            default: acc_o = acc_i;
        endcase
    end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              run_i,
    output logic [ADDR_W-1:0] imem_addr_o,
    input  logic [DATA_W-1:0] imem_data_i,
    output logic [DATA_W-1:0] acc_o,
    output logic              halted_o
);

    typedef struct packed {
        cpu_state_e        state;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] opnd;
    } core_regs_t;

    localparam core_regs_t RESET_REGS = '{
        state: ST_FETCH,
        pc:    '0,
        acc:   '0,
        ir:    '0,
        opnd:  '0
    };

    core_regs_t        r_d, r_q;
    op_class_e         op_cls;
    logic [DATA_W-1:0] alu_res;
    logic [ADDR_W-1:0] pc_inc;

    acc_cpu_decode #(
        .DATA_W (DATA_W)
    ) u_decode (
        .instr_i (r_q.ir),
        .op_o    (op_cls)
    );

    acc_cpu_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op_i   (op_cls),
        .acc_i  (r_q.acc),
        .opnd_i (r_q.opnd),
        .acc_o  (alu_res)
    );

    assign pc_inc = r_q.pc + ADDR_W'(1);

    always_comb begin
        r_d = r_q;
        if (run_i) begin
            unique case (r_q.state)
                ST_FETCH: begin
                    r_d.ir    = imem_data_i;
                    r_d.pc    = pc_inc;
                    r_d.state = ST_DECODE;
                end
                ST_DECODE: begin
                    unique case (op_cls)
                        OP_HALT: r_d.state = ST_HALT;
                        OP_CLR:  r_d.state = ST_EXEC;
                        OP_ADDI: r_d.state = ST_OPFETCH;
                        default: r_d.state = ST_FETCH;
                    endcase
                end
                ST_OPFETCH: begin
                    r_d.opnd  = imem_data_i;
                    r_d.pc    = pc_inc;
                    r_d.state = ST_EXEC;
                end
                ST_EXEC: begin
                    r_d.acc   = alu_res;
                    r_d.state = ST_FETCH;
                end
                ST_HALT: begin
                    r_d.state = ST_HALT;
                end
                default: begin
                    r_d.state = ST_HALT;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= RESET_REGS;
        end else begin
            r_q <= r_d;
        end
    end

    assign imem_addr_o = r_q.pc;
    assign acc_o       = r_q.acc;
    assign halted_o    = (r_q.state == ST_HALT);

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              run_i,
    input logic [ADDR_W-1:0] imem_addr_o,
    input logic [DATA_W-1:0] acc_o,
    input logic              halted_o
);

    // R5: the halted flag holds until reset
    p_halt_sticky_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        halted_o |=> halted_o)
        else $error("halted flag dropped without reset");

    // R5: nothing moves once halted
    p_halt_frozen_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        halted_o |=> ($stable(acc_o) && $stable(imem_addr_o)))
        else $error("state changed while halted");

    // R6: the address only ever steps by one
    p_pc_step_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(imem_addr_o) |-> (imem_addr_o == ADDR_W'($past(imem_addr_o) + ADDR_W'(1))))
        else $error("program address jumped");

    // R9: a paused core holds its state
    p_pause_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (!run_i && !halted_o) |=> ($stable(acc_o) && $stable(imem_addr_o) && !halted_o))
        else $error("core moved while paused");

endmodule

bind acc_cpu_core acc_cpu_core_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .run_i       (run_i),
    .imem_addr_o (imem_addr_o),
    .acc_o       (acc_o),
    .halted_o    (halted_o)
);

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b1;
    logic [7:0] imem_addr;
    logic [7:0] imem_data;
    logic [7:0] acc;
    logic       halted;
    logic [7:0] mem [256];

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    assign imem_data = mem[imem_addr];

    acc_cpu_core dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .run_i       (run),
        .imem_addr_o (imem_addr),
        .imem_data_i (imem_data),
        .acc_o       (acc),
        .halted_o    (halted)
    );

    // Program words packed byte 0 at the LSB; expected acc, end address, cycles
    typedef struct packed {
        logic [63:0] prog;
        logic [7:0]  acc;
        logic [7:0]  pc;
        logic [7:0]  cyc;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{64'h0000_0005_0207_0201, 8'd12, 8'd6, 8'd13}, // R2 R3 R8: 1,2,7,2,5,0
        '{64'h0000_0000_6402_C802, 8'd44, 8'd5, 8'd10}, // R4: 200+100 wraps
        '{64'h0000_0003_0201_0902, 8'd3,  8'd6, 8'd13}, // R2: clear mid-program
        '{64'h0000_0102_FF04_0207, 8'd5,  8'd7, 8'd14}, // R7: 7 and 255 skipped
        '{64'h0000_0000_0000_0000, 8'd0,  8'd1, 8'd2},  // R5: immediate halt
        '{64'h0000_0000_0202_0002, 8'd2,  8'd5, 8'd10}, // R3: operands 0 and 2 are data
        '{64'h0000_0000_0102_FF02, 8'd0,  8'd5, 8'd10}  // R4: 255+1 wraps to 0
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load(input logic [63:0] prog);
        for (int i = 0; i < 256; i++) mem[i] = 8'd0;
        for (int i = 0; i < 8; i++) mem[i] = prog[i*8 +: 8];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        run = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_halt(output int n);
        n = 0;
        while (!halted && n < 300) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
    endtask

    task automatic step(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'd0;
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] a_snap, p_snap;

        // R1: reset state
        load(VEC[0].prog);
        do_reset();
        check(acc == 8'd0, "R1 acc after reset", acc, 0);
        check(imem_addr == 8'd0, "R1 address after reset", imem_addr, 0);
        check(halted == 1'b0, "R1 halted after reset", halted, 0);

        // Vector table: R2 R3 R4 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            load(VEC[v].prog);
            do_reset();
            run_to_halt(n);
            check(acc == VEC[v].acc, $sformatf("R2/R3/R4/R7 acc vec %0d", v), acc, VEC[v].acc);
            check(imem_addr == VEC[v].pc, $sformatf("R6 end address vec %0d", v), imem_addr, VEC[v].pc);
            check(n == int'(VEC[v].cyc), $sformatf("R8 cycles vec %0d", v), n, VEC[v].cyc);
        end

        // R5: after halt, rewrite memory with add words; nothing moves
        load(VEC[0].prog);
        do_reset();
        run_to_halt(n);
        for (int i = 0; i < 256; i++) mem[i] = 8'd2;
        step(20);
        check(halted == 1'b1, "R5 halted held", halted, 1);
        check(acc == 8'd12, "R5 acc frozen", acc, 12);
        check(imem_addr == 8'd6, "R5 address frozen", imem_addr, 6);

        // R1: reset after a nonzero result clears everything
        load(VEC[0].prog);
        do_reset();
        check(acc == 8'd0, "R1 acc cleared from 12", acc, 0);
        check(halted == 1'b0, "R1 halted cleared", halted, 0);
        check(imem_addr == 8'd0, "R1 address cleared", imem_addr, 0);

        // R9: pause mid-program
        load(VEC[0].prog);
        do_reset();
        step(5);
        run = 1'b0;
        a_snap = acc;
        p_snap = imem_addr;
        step(10);
        check(acc == a_snap, "R9 acc held while paused", acc, a_snap);
        check(imem_addr == p_snap, "R9 address held while paused", imem_addr, p_snap);
        check(halted == 1'b0, "R9 no halt while paused", halted, 0);
        run = 1'b1;
        run_to_halt(n);
        check(n + 5 == 13, "R9 cycles after resume", n + 5, 13);
        check(acc == 8'd12, "R9 result after resume", acc, 12);

        // R1: reset in mid-run restarts from address 0
        load(VEC[2].prog);
        do_reset();
        step(6);
        do_reset();
        check(imem_addr == 8'd0, "R1 mid-run reset address", imem_addr, 0);
        run_to_halt(n);
        check(n == 13, "R1 restart cycles", n, 13);
        check(acc == 8'd3, "R1 restart result", acc, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule